// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block decides, cycle by cycle, whether the source side of a three-phase bridge may conduct. A digital trip from the current-sense comparator first passes through a two-stage synchronizer. The trip is acted on only while the bridge is driving and no blanking window is open. When a trip is accepted, the source drive turns off for a fixed number of oscillator ticks. That off period is split into a fast-decay part followed by a slow-decay part, and a two-bit decay code sets the size of the fast part.

When the off period ends, the source drive turns back on and a blanking window masks the comparator while switching transients settle. A rising external enable or a change of direction also restarts this window. While the external enable is low, the block holds the source off and reports the decay style chosen by a mode pin. A synchronous-rectification gate is reported during any decay. A zero-current flag drops that gate at once and keeps it low until the decay ends. Counters move only on cycles where the oscillator tick enable is high.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge at which it is sampled high, the outputs go to: source on, window open, no decay, gate low. After release the window stays open for the blank length of ticks (6 when `blank_long`=0).
- R2: The trip is synchronized through two flops. An accepted trip pulse that is high at edge n drops `src_on` at edge n+3. The source then stays off for exactly 96 ticks.
- R3: The decay code `decay_sel` sets the number of leading fast ticks in the off period: 2'b00 gives 0, 2'b01 gives 14, 2'b10 gives 46 and 2'b11 gives 96. The remaining ticks are slow decay.
- R4: When the off period ends, `blank_win` stays high for 6 ticks (`blank_long`=0) or 12 ticks (`blank_long`=1). Trips seen during the off period or while the window is open leave `src_on` unchanged.
- R5: A rising edge on `ext_en`, or any change of `dir`, reloads the window to its full length on the next edge.
- R6: While `ext_en` is low, `src_on` is 0 on the next edge. `ext_slow`=0 reports fast decay and `ext_slow`=1 reports slow decay. Trips are ignored in this state.
- R7: `sr_gate` follows `sr_en` during decay. It goes low on the edge after `zero_i` is seen high and stays low until that decay interval ends.
- R8: The off and blanking counters advance only on cycles with `tick` high. With `tick` low, the current phase is held.
- R9: `fast_dec` and `slow_dec` are never both high, and neither is high while `src_on` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oscillator tick enable |
| trip_raw | input | 1 | Asynchronous sense-comparator trip |
| decay_sel | input | 2 | Fast-decay share code |
| blank_long | input | 1 | 0: short window, 1: long window |
| ext_en | input | 1 | External drive enable |
| ext_slow | input | 1 | Decay style while ext_en is low (1 = slow) |
| dir | input | 1 | Rotation direction; any change restarts blanking |
| sr_en | input | 1 | Synchronous rectification allowed |
| zero_i | input | 1 | Winding current has reached zero |
| src_on | output | 1 | Source driver may conduct |
| fast_dec | output | 1 | Fast-decay phase active |
| slow_dec | output | 1 | Slow-decay phase active |
| blank_win | output | 1 | Comparator blanking window open |
| sr_gate | output | 1 | Synchronous-rectification gate enable |

## Verification
Each of the four decay codes is run through a full trip cycle, and every cycle of the off period and the window is compared. This separates the fast/slow split points from one another and confirms the 96-tick length for each code. Extra trip pulses are placed in the middle of the off period and inside the window, which shows that trips are masked there rather than starting a new off period. Separate sequences exercise the following: the enable drop with each decay style, enable rise and direction toggles restarting the window, zero-current pulses during decay, and long tick stalls. These show, in turn, that the window restarts on its own triggers, that the gate latches low, and that only ticks move time forward.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    DEC_SLOW   = 2'b00,
    DEC_MIX_LO = 2'b01,
    DEC_MIX_HI = 2'b10,
    DEC_FAST   = 2'b11
  } decay_code_e;

  // Number of leading fast ticks within an off period of 'total' ticks.
  function automatic int unsigned fast_share(input logic [1:0] code, input int unsigned total);
    case (decay_code_e'(code))
      DEC_SLOW:   return 0;
      DEC_MIX_LO: return (total * 15) / 100;
      DEC_MIX_HI: return (total * 48) / 100;
      default:    return total;
    endcase
  endfunction

endpackage

// File: rtl/chop_trip_sync.sv
module chop_trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
  parameter int OFF_TICKS = 96,
  localparam int CW = $clog2(OFF_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [CW-1:0] fast_len,
  output logic          off_q,
  output logic          off_n,
  output logic          fast_n,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    off_n = off_q;
    cnt_n = cnt_q;
    done  = 1'b0;
    if (!off_q) begin
      if (start) begin
        off_n = 1'b1;
        cnt_n = CW'(OFF_TICKS);
      end
    end else if (tick) begin
      if (cnt_q == CW'(1)) begin
        off_n = 1'b0;
        cnt_n = '0;
        done  = 1'b1;
      end else begin
        cnt_n = cnt_q - CW'(1);
      end
    end
    // remaining count above (total - fast share) means still in the fast part
    fast_n = off_n && (cnt_n > (CW'(OFF_TICKS) - fast_len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      off_q <= off_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12,
  localparam int BMAX = (BLANK_LONG > BLANK_SHORT) ? BLANK_LONG : BLANK_SHORT,
  localparam int BW   = $clog2(BMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic blank_long,
  output logic busy_q,
  output logic busy_n
);
  logic [BW-1:0] cnt_q, cnt_n, load_val;

  assign load_val = blank_long ? BW'(BLANK_LONG) : BW'(BLANK_SHORT);

  always_comb begin
    cnt_n = cnt_q;
    if (restart)                     cnt_n = load_val;
    else if (tick && cnt_q != '0)    cnt_n = cnt_q - BW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= load_val;
    else     cnt_q <= cnt_n;
  end

  assign busy_q = (cnt_q != '0);
  assign busy_n = (cnt_n != '0);
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int OFF_TICKS   = 96,
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       trip_raw,
  input  logic [1:0] decay_sel,
  input  logic       blank_long,
  input  logic       ext_en,
  input  logic       ext_slow,
  input  logic       dir,
  input  logic       sr_en,
  input  logic       zero_i,
  output logic       src_on,
  output logic       fast_dec,
  output logic       slow_dec,
  output logic       blank_win,
  output logic       sr_gate
);
  localparam int CW = $clog2(OFF_TICKS + 1);

  logic          trip_s;
  logic          off_q, off_n, fast_n, off_done;
  logic          blank_busy, blank_busy_n;
  logic          en_q, dir_q, zs_q;
  logic          accept, restart;
  logic [CW-1:0] fast_len;
  logic          src_d, fast_d, slow_d, decay_d, zs_d, sr_d;

  chop_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(trip_raw), .q(trip_s)
  );

  assign fast_len = CW'(chop_pkg::fast_share(decay_sel, OFF_TICKS));
  assign accept   = !off_q && trip_s && !blank_busy && ext_en;

  chop_off_timer #(.OFF_TICKS(OFF_TICKS)) u_off (
    .clk(clk), .rst(rst), .tick(tick), .start(accept), .fast_len(fast_len),
    .off_q(off_q), .off_n(off_n), .fast_n(fast_n), .done(off_done)
  );

  assign restart = (ext_en && !en_q) || (dir != dir_q) || off_done;

  chop_blank_timer #(.BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG)) u_blank (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .blank_long(blank_long),
    .busy_q(blank_busy), .busy_n(blank_busy_n)
  );

  always_comb begin
    if (!ext_en) begin
      src_d  = 1'b0;
      fast_d = !ext_slow;
      slow_d = ext_slow;
    end else if (off_n) begin
      src_d  = 1'b0;
      fast_d = fast_n;
      slow_d = !fast_n;
    end else begin
      src_d  = 1'b1;
      fast_d = 1'b0;
      slow_d = 1'b0;
    end
    decay_d = fast_d || slow_d;
    zs_d    = decay_d && (zs_q || zero_i);
    sr_d    = sr_en && decay_d && !zs_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_on    <= 1'b1;
      fast_dec  <= 1'b0;
      slow_dec  <= 1'b0;
      blank_win <= 1'b1;
      sr_gate   <= 1'b0;
      zs_q      <= 1'b0;
      en_q      <= ext_en;
      dir_q     <= dir;
    end else begin
      src_on    <= src_d;
      fast_dec  <= fast_d;
      slow_dec  <= slow_d;
      blank_win <= blank_busy_n;
      sr_gate   <= sr_d;
      zs_q      <= zs_d;
      en_q      <= ext_en;
      dir_q     <= dir;
    end
  end
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ext_en,
  input logic sr_en,
  input logic zero_i,
  input logic src_on,
  input logic fast_dec,
  input logic slow_dec,
  input logic blank_win,
  input logic sr_gate
);
  AST_DECAY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fast_dec && slow_dec)); // R9
  AST_DECAY_NO_SRC: assert property (@(posedge clk) disable iff (rst)
    (fast_dec || slow_dec) |-> !src_on); // R9
  AST_EN_LOW_NO_SRC: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> !src_on); // R6
  AST_SR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    sr_gate |-> $past(sr_en)); // R7
  AST_ZERO_DROPS_SR: assert property (@(posedge clk) disable iff (rst)
    zero_i |=> !sr_gate); // R7
  AST_BLANK_HOLDS_SRC: assert property (@(posedge clk) disable iff (rst)
    (blank_win && src_on && ext_en) |=> src_on); // R4
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (.*);

// File: tb/chop_ctrl_tb.sv
`timescale 1ns/1ps
module chop_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       trip_raw = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic       blank_long = 1'b0;
  logic       ext_en = 1'b1;
  logic       ext_slow = 1'b0;
  logic       dir = 1'b0;
  logic       sr_en = 1'b1;
  logic       zero_i = 1'b0;
  logic       src_on, fast_dec, slow_dec, blank_win, sr_gate;

  chop_ctrl u_dut (
    .clk(clk), .rst(rst), .tick(tick), .trip_raw(trip_raw), .decay_sel(decay_sel),
    .blank_long(blank_long), .ext_en(ext_en), .ext_slow(ext_slow), .dir(dir),
    .sr_en(sr_en), .zero_i(zero_i), .src_on(src_on), .fast_dec(fast_dec),
    .slow_dec(slow_dec), .blank_win(blank_win), .sr_gate(sr_gate)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         at;
    logic [4:0] exp;
    string      req;
  } sb_item_t;

  sb_item_t sb[$];
  sb_item_t cur;
  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] vec(bit s, bit f, bit sl, bit b, bit r);
    return {s, f, sl, b, r};
  endfunction

  task automatic push(int at, logic [4:0] e, string r);
    sb_item_t it;
    it.at = at; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: compares outputs {src,fast,slow,blank,sr} against queued items
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      cur = sb.pop_front();
      total++;
      if (cur.at != cyc || {src_on, fast_dec, slow_dec, blank_win, sr_gate} !== cur.exp) begin
        fails++;
        $display("FAIL %s cycle %0d: got %b expected %b", cur.req, cur.at,
                 {src_on, fast_dec, slow_dec, blank_win, sr_gate}, cur.exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000 && !finished) begin
      finished = 1'b1;
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // R2 R3 R4 R7: full trip cycle with extra trips during off and blanking
  task automatic run_trip(logic [1:0] code, bit blong, bit sren, int zk);
    int c, f_len, blen;
    @(negedge clk);
    decay_sel = code; blank_long = blong; sr_en = sren;
    repeat (2) @(negedge clk);
    c = cyc;
    case (code)
      2'b00: f_len = 0;
      2'b01: f_len = 14;
      2'b10: f_len = 46;
      default: f_len = 96;
    endcase
    blen = blong ? 12 : 6;
    for (int k = 1; k <= 99 + blen; k++) begin
      if (k <= 2) push(c + k, vec(1, 0, 0, 0, 0), "R2");
      else if (k <= 98) begin
        bit f, s;
        f = (k - 3) < f_len;
        s = sren && !(zk > 0 && k > zk);
        push(c + k, vec(0, f, !f, 0, s), "R2 R3 R7 R9");
      end else push(c + k, vec(1, 0, 0, k < 99 + blen, 0), "R4");
    end
    trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
    if (zk > 0) begin
      wait_to(c + zk); zero_i = 1'b1;
      wait_to(c + zk + 1); zero_i = 1'b0;
    end
    wait_to(c + 50); trip_raw = 1'b1;
    wait_to(c + 51); trip_raw = 1'b0;
    wait_to(c + 100); trip_raw = 1'b1;
    wait_to(c + 101); trip_raw = 1'b0;
    wait_to(c + blen + 104);
  endtask

  // R6 R5: enable low with chosen decay style, trip ignored, rise restarts window
  task automatic en_test(bit s);
    int c;
    @(negedge clk);
    c = cyc;
    for (int k = 1; k <= 5; k++) push(c + k, vec(0, !s, s, 0, sr_en), "R6");
    for (int k = 6; k <= 11; k++) push(c + k, vec(1, 0, 0, 1, 0), "R5");
    push(c + 12, vec(1, 0, 0, 0, 0), "R5");
    ext_slow = s; ext_en = 1'b0; trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
    wait_to(c + 5); ext_en = 1'b1;
    wait_to(c + 14); ext_slow = 1'b0;
  endtask

  // R5 R4: direction change restarts window, trip inside it ignored
  task automatic dir_test();
    int c;
    @(negedge clk);
    c = cyc;
    for (int k = 1; k <= 6; k++) push(c + k, vec(1, 0, 0, 1, 0), "R5 R4");
    push(c + 7, vec(1, 0, 0, 0, 0), "R5");
    dir = ~dir; trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
    wait_to(c + 9);
  endtask

  // R8: ticks held low freeze the off period
  task automatic tick_test();
    int c;
    @(negedge clk); decay_sel = 2'b11; blank_long = 1'b0; sr_en = 1'b1;
    repeat (2) @(negedge clk);
    c = cyc;
    push(c + 10,  vec(0, 1, 0, 0, 1), "R8");
    push(c + 60,  vec(0, 1, 0, 0, 1), "R8");
    push(c + 110, vec(0, 1, 0, 0, 1), "R8");
    push(c + 198, vec(0, 1, 0, 0, 1), "R8");
    push(c + 199, vec(1, 0, 0, 1, 0), "R8");
    trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
    wait_to(c + 10); tick = 1'b0;
    wait_to(c + 110); tick = 1'b1;
    wait_to(c + 210);
  endtask

  // R1: synchronous reset in the middle of an off period
  task automatic reset_mid();
    int c;
    @(negedge clk); decay_sel = 2'b11;
    repeat (2) @(negedge clk);
    c = cyc;
    push(c + 10, vec(0, 1, 0, 0, 1), "R1");
    push(c + 11, vec(1, 0, 0, 1, 0), "R1");
    push(c + 16, vec(1, 0, 0, 1, 0), "R1");
    push(c + 17, vec(1, 0, 0, 0, 0), "R1");
    trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
    wait_to(c + 10); rst = 1'b1;
    wait_to(c + 11); rst = 1'b0;
    wait_to(c + 20);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    c = cyc;
    push(c + 1, vec(1, 0, 0, 1, 0), "R1");
    push(c + 5, vec(1, 0, 0, 1, 0), "R1");
    push(c + 6, vec(1, 0, 0, 0, 0), "R1");
    rst = 1'b0;
    wait_to(c + 10);
    run_trip(2'b00, 1'b0, 1'b1, 0);
    run_trip(2'b01, 1'b0, 1'b1, 0);
    run_trip(2'b10, 1'b0, 1'b0, 0);
    run_trip(2'b11, 1'b1, 1'b1, 20);
    run_trip(2'b01, 1'b0, 1'b1, 30);
    en_test(1'b0);
    en_test(1'b1);
    dir_test();
    tick_test();
    reset_mid();
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails += sb.size(); total += sb.size();
      $display("FAIL R1 leftover: got %0d pending expected 0", sb.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule